// File: doc/BRIEF.md
# Performance Monitor Counter Bank

A bank of event counters for one processor core, accessed by software through a plain read/write strobe register bus. A single global control word switches counting on and off for the whole bank. Each counter has a 32-bit value word, a control word and a status word. The control word chooses one of several 16-bit event groups and a sub-event mask within it, sets a privilege filter, and selects whether an overflow may interrupt. Every cycle a counter advances by one when at least one unmasked sub-event in its group pulses and the current privilege passes the filter.

Software normally preloads a counter with the negative of a sampling period. The counter wraps after that many events, latches an overflow flag, and may assert a shared interrupt line. It holds these status bits until software writes ones back to them. A dedicated select code lets a counter count the wraps of the counter just below it, which forms a 64-bit or longer count.

Top module: `pmc_bank`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: The global word (byte offset 0x000) keeps only bit 0, the master enable. While this bit is clear no counter advances. A write to it takes effect from the next cycle.
- R3: Decoding uses `bus_addr[ADDR_W-1:2]` and ignores the two low address bits. The value word of counter i is at 0x080+4i, its control word at 0x100+4i and its status word at 0x180+4i, for i below N_CNT. A read of any other offset returns zero, and a write to one changes no register. `bus_rdata` is zero while `bus_rd` is low.
- R4: The control word stores only these fields: bit 0 interrupt enable, bit 3 count-in-kernel, bits 7:4 trace level, bits 12:8 group select and bits 31:16 sub-event mask. All other bits read back as zero.
- R5: For a group select g other than 1 and below N_GROUPS, the counter steps by one in a cycle when `evt_grp[16g+15:16g]` ANDed with the mask is non-zero. The step also needs the enable and the privilege filter. A select at or above N_GROUPS never counts.
- R6: The privilege filter passes when `priv_lvl` is at most the trace level, or when `kern_mode` is high and count-in-kernel is set.
- R7: A step from 0xFFFFFFFF to 0 is a wrap. It sets status bit 0 (overflow). When the interrupt enable is set, it also sets status bit 4 (interrupt asserted).
- R8: Writing a 1 to status bit 0 or bit 4 clears that bit, and zero bits leave it alone. A wrap in the same cycle as the clear leaves the bit set.
- R9: `irq_o` is the OR of status bit 4 over all counters.
- R10: Group select 1 makes counter i step in each cycle where counter i-1 wraps, when the global enable is set. The mask and the privilege filter do not apply to it. Counter 0 with select 1 never steps.
- R11: A write to a value word loads it. If that write falls in a cycle where the counter would also step, the write wins and no wrap is recorded.
- R12: Writing zero to a control word stops that counter. Its value and status stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| evt_grp | input | N_GROUPS*16 | Event groups, 16 sub-event pulses each |
| priv_lvl | input | 4 | Current privilege level |
| kern_mode | input | 1 | Core is in kernel mode |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
An off-by-one or a mis-gated step makes a counter's value differ from the reference at the next read, and any read of that counter shows it. A missed or spurious wrap shows on `irq_o` in the cycle after the wrap when the interrupt enable is set. A chained counter shows it one wrap later. Broken clearing leaves `irq_o` high in the cycle after the status write. Because `irq_o` is compared every clock, interrupt faults show within one cycle, while value and status faults wait for the next register read.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DW      = 32;
  localparam int SUB_W   = 16;
  localparam int SEL_W   = 5;
  localparam int LVL_W   = 4;

  // word indices of the register regions (byte offset / 4)
  localparam int GLB_WORD = 0;
  localparam int VAL_BASE = 32;
  localparam int CTL_BASE = 64;
  localparam int ST_BASE  = 96;

  localparam logic [DW-1:0]    CTL_KEEP  = 32'hFFFF_1FF9;
  localparam logic [SEL_W-1:0] SEL_CHAIN = 5'd1;

  typedef struct packed {
    logic [SUB_W-1:0] mask;
    logic [2:0]       rsv_hi;
    logic [SEL_W-1:0] sel;
    logic [LVL_W-1:0] tlvl;
    logic             kcnt;
    logic [1:0]       rsv_lo;
    logic             ien;
  } pmc_ctl_t;

  function automatic logic priv_ok(input pmc_ctl_t c, input logic [LVL_W-1:0] lvl,
                                   input logic kern);
    return (lvl <= c.tlvl) || (kern && c.kcnt);
  endfunction

  // returns {carry, value+1}
  function automatic logic [DW:0] bump(input logic [DW-1:0] v);
    return {1'b0, v} + {{DW{1'b0}}, 1'b1};
  endfunction

  function automatic logic [DW-1:0] status_word(input logic ovf, input logic ia);
    return {{(DW-5){1'b0}}, ia, 3'b000, ovf};
  endfunction
endpackage

// File: rtl/pmc_slice.sv
module pmc_slice
  import pmc_pkg::*;
#(
  parameter int N_GROUPS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      glb_en,
  input  logic [N_GROUPS*SUB_W-1:0] grp_flat,
  input  logic [LVL_W-1:0]          priv_lvl,
  input  logic                      kern_mode,
  input  logic                      chain_in,
  input  logic                      wr_val,
  input  logic                      wr_ctl,
  input  logic                      wr_st,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             cnt_q,
  output pmc_ctl_t                  ctl_q,
  output logic                      ovf_q,
  output logic                      ia_q,
  output logic                      step_o,
  output logic                      wrap_o
);
  logic [SUB_W-1:0] grp_vec;
  logic             ext_hit;
  logic             carry;
  logic [DW-1:0]    cnt_nxt;

  always_comb begin
    grp_vec = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (ctl_q.sel == SEL_W'(g)) grp_vec = grp_flat[g*SUB_W +: SUB_W];
    end
  end

  assign ext_hit = (ctl_q.sel != SEL_CHAIN) && (|(grp_vec & ctl_q.mask)) &&
                   priv_ok(ctl_q, priv_lvl, kern_mode);
  assign step_o  = glb_en && ((ctl_q.sel == SEL_CHAIN) ? chain_in : ext_hit);
  assign {carry, cnt_nxt} = bump(cnt_q);
  assign wrap_o  = step_o && !wr_val && carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ctl_q <= '0;
      ovf_q <= 1'b0;
      ia_q  <= 1'b0;
    end else begin
      if (wr_val)      cnt_q <= wdata;
      else if (step_o) cnt_q <= cnt_nxt;
      if (wr_ctl) ctl_q <= pmc_ctl_t'(wdata & CTL_KEEP);
      ovf_q <= (ovf_q && !(wr_st && wdata[0])) || wrap_o;
      ia_q  <= (ia_q  && !(wr_st && wdata[4])) || (wrap_o && ctl_q.ien);
    end
  end
endmodule

// File: rtl/pmc_regbus.sv
module pmc_regbus
  import pmc_pkg::*;
#(
  parameter int N_CNT  = 4,
  parameter int ADDR_W = 12
) (
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                glb_q,
  input  logic [N_CNT*DW-1:0] cnt_flat,
  input  logic [N_CNT*DW-1:0] ctl_flat,
  input  logic [N_CNT-1:0]    ovf_v,
  input  logic [N_CNT-1:0]    ia_v,
  output logic                wr_glb,
  output logic [N_CNT-1:0]    wr_val,
  output logic [N_CNT-1:0]    wr_ctl,
  output logic [N_CNT-1:0]    wr_st,
  output logic                hit_o,
  output logic [DW-1:0]       rdata
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [DW-1:0]     rd_mux;

  assign word = bus_addr[ADDR_W-1:2];

  always_comb begin
    wr_glb = 1'b0;
    wr_val = '0;
    wr_ctl = '0;
    wr_st  = '0;
    hit_o  = 1'b0;
    rd_mux = '0;
    if (word == WORD_W'(GLB_WORD)) begin
      hit_o  = 1'b1;
      wr_glb = bus_wr;
      rd_mux = {{(DW-1){1'b0}}, glb_q};
    end
    for (int i = 0; i < N_CNT; i++) begin
      if (word == WORD_W'(VAL_BASE + i)) begin
        hit_o     = 1'b1;
        wr_val[i] = bus_wr;
        rd_mux    = cnt_flat[i*DW +: DW];
      end
      if (word == WORD_W'(CTL_BASE + i)) begin
        hit_o     = 1'b1;
        wr_ctl[i] = bus_wr;
        rd_mux    = ctl_flat[i*DW +: DW];
      end
      if (word == WORD_W'(ST_BASE + i)) begin
        hit_o     = 1'b1;
        wr_st[i]  = bus_wr;
        rd_mux    = status_word(ovf_v[i], ia_v[i]);
      end
    end
  end

  assign rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int N_CNT    = 4,
  parameter int N_GROUPS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [N_GROUPS*16-1:0]    evt_grp,
  input  logic [3:0]                priv_lvl,
  input  logic                      kern_mode,
  output logic                      irq_o
);
  logic                gen_q;
  logic                wr_glb;
  logic                bus_hit;
  logic [N_CNT-1:0]    wr_val_v, wr_ctl_v, wr_st_v;
  logic [N_CNT-1:0]    ovf_v, ia_v, step_v, wrap_v, ien_v, ctlz_v;
  logic [N_CNT*DW-1:0] cnt_flat, ctl_flat;

  always_ff @(posedge clk) begin
    if (!rst_n)      gen_q <= 1'b0;
    else if (wr_glb) gen_q <= bus_wdata[0];
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    pmc_ctl_t ctl_i;
    logic     chain_i;
    if (i == 0) begin : g_head
      assign chain_i = 1'b0;
    end else begin : g_link
      assign chain_i = wrap_v[i-1];
    end

    pmc_slice #(.N_GROUPS(N_GROUPS)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .glb_en    (gen_q),
      .grp_flat  (evt_grp),
      .priv_lvl  (priv_lvl),
      .kern_mode (kern_mode),
      .chain_in  (chain_i),
      .wr_val    (wr_val_v[i]),
      .wr_ctl    (wr_ctl_v[i]),
      .wr_st     (wr_st_v[i]),
      .wdata     (bus_wdata),
      .cnt_q     (cnt_flat[i*DW +: DW]),
      .ctl_q     (ctl_i),
      .ovf_q     (ovf_v[i]),
      .ia_q      (ia_v[i]),
      .step_o    (step_v[i]),
      .wrap_o    (wrap_v[i])
    );

    assign ctl_flat[i*DW +: DW] = ctl_i;
    assign ien_v[i]  = ctl_i.ien;
    assign ctlz_v[i] = (ctl_i == '0);
  end

  pmc_regbus #(.N_CNT(N_CNT), .ADDR_W(ADDR_W)) u_bus (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .glb_q    (gen_q),
    .cnt_flat (cnt_flat),
    .ctl_flat (ctl_flat),
    .ovf_v    (ovf_v),
    .ia_v     (ia_v),
    .wr_glb   (wr_glb),
    .wr_val   (wr_val_v),
    .wr_ctl   (wr_ctl_v),
    .wr_st    (wr_st_v),
    .hit_o    (bus_hit),
    .rdata    (bus_rdata)
  );

  assign irq_o = |ia_v;
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk #(
  parameter int N_CNT = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                glb_en,
  input logic [N_CNT-1:0]    wrap_v,
  input logic [N_CNT-1:0]    ovf_v,
  input logic [N_CNT-1:0]    ia_v,
  input logic [N_CNT-1:0]    ien_v,
  input logic [N_CNT-1:0]    ctlz_v,
  input logic [N_CNT-1:0]    wr_val_v,
  input logic [N_CNT*32-1:0] cnt_flat,
  input logic                irq_o,
  input logic                bus_rd,
  input logic                bus_hit,
  input logic [31:0]         bus_rdata
);
  for (genvar i = 0; i < N_CNT; i++) begin : g_a
    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_v[i] |=> ovf_v[i]);
    // R7
    ia_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ia_v[i] && !(wrap_v[i] && ien_v[i])) |=> !ia_v[i]);
    // R2
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && !wr_val_v[i]) |=> $stable(cnt_flat[i*32 +: 32]));
    // R12
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctlz_v[i] && !wr_val_v[i]) |=> $stable(cnt_flat[i*32 +: 32]));
  end

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(wrap_v & ien_v)));
  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_hit) |-> (bus_rdata == 32'd0));
endmodule

bind pmc_bank pmc_bank_chk #(.N_CNT(N_CNT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (gen_q),
  .wrap_v    (wrap_v),
  .ovf_v     (ovf_v),
  .ia_v      (ia_v),
  .ien_v     (ien_v),
  .ctlz_v    (ctlz_v),
  .wr_val_v  (wr_val_v),
  .cnt_flat  (cnt_flat),
  .irq_o     (irq_o),
  .bus_rd    (bus_rd),
  .bus_hit   (bus_hit),
  .bus_rdata (bus_rdata)
);

// File: tb/pmc_bank_tb.sv
module pmc_bank_tb;
  localparam int NC = 4;
  localparam int NG = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NG*16-1:0] evt = '0;
  logic [3:0]    priv = '0;
  logic          kern = 1'b0;
  logic          irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pmc_bank #(.N_CNT(NC), .N_GROUPS(NG), .ADDR_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_grp(evt), .priv_lvl(priv), .kern_mode(kern), .irq_o(irq));

  // ---------------- reference model ----------------
  logic [31:0] m_val [NC];
  logic [31:0] m_ctl [NC];
  bit          m_ovf [NC];
  bit          m_ia  [NC];
  bit          m_gen;

  function automatic int region(input logic [11:0] a, output int idx);
    int w = int'(a) / 4;
    idx = 0;
    if (w == 0) return 1;
    if (w >= 32 && w < 32 + NC) begin idx = w - 32; return 2; end
    if (w >= 64 && w < 64 + NC) begin idx = w - 64; return 3; end
    if (w >= 96 && w < 96 + NC) begin idx = w - 96; return 4; end
    return 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int k;
    int r = region(a, k);
    case (r)
      1: return {31'd0, m_gen};
      2: return m_val[k];
      3: return m_ctl[k];
      4: return (m_ovf[k] ? 32'h1 : 32'h0) | (m_ia[k] ? 32'h10 : 32'h0);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        m_val[i] = 0; m_ctl[i] = 0; m_ovf[i] = 0; m_ia[i] = 0;
      end
      m_gen = 0;
    end else begin
      bit pw;
      int r, k;
      pw = 0;
      r = bus_wr ? region(bus_addr, k) : 0;
      for (int i = 0; i < NC; i++) begin
        bit st, w, filt;
        int sel;
        sel  = int'(m_ctl[i][12:8]);
        filt = (priv <= m_ctl[i][7:4]) || (kern && m_ctl[i][3]);
        w = 0;
        if (!m_gen) st = 0;
        else if (sel == 1) st = pw;
        else st = (sel < NG) && filt && ((evt[sel*16 +: 16] & m_ctl[i][31:16]) != 0);
        if (r == 2 && k == i) m_val[i] = bus_wdata;
        else if (st) begin
          w = (m_val[i] == 32'hFFFF_FFFF);
          m_val[i] = m_val[i] + 1;
        end
        if (r == 4 && k == i) begin
          if (bus_wdata[0]) m_ovf[i] = 0;
          if (bus_wdata[4]) m_ia[i] = 0;
        end
        if (w) begin
          m_ovf[i] = 1;
          if (m_ctl[i][0]) m_ia[i] = 1;
        end
        pw = w;
      end
      if (r == 3) m_ctl[k] = bus_wdata & 32'hFFFF_1FF9;
      if (r == 1) m_gen = bus_wdata[0];
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // R9: interrupt line against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit any;
      any = 0;
      for (int i = 0; i < NC; i++) any |= m_ia[i];
      chk("R9 irq", {31'd0, irq}, {31'd0, any});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2;
    chk(tag, bus_rdata, m_read(a));
    bus_rd = 1'b0;
    #1;
    chk({tag, " rd-low"}, bus_rdata, 32'd0);
  endtask

  task automatic rd_exp(input string tag, input logic [11:0] a, input logic [31:0] e);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2;
    chk(tag, bus_rdata, e);
    chk({tag, " model"}, m_read(a), e);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int g, input logic [15:0] v, input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      evt = '0;
      evt[g*16 +: 16] = v;
    end
    @(negedge clk);
    evt = '0;
  endtask

  task automatic rd_all(input string tag);
    rd(tag, 12'h000);
    for (int i = 0; i < NC; i++) begin
      rd(tag, 12'(12'h080 + 4*i));
      rd(tag, 12'(12'h100 + 4*i));
      rd(tag, 12'(12'h180 + 4*i));
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_all("R1 reset");
    rd_exp("R1 ctl0", 12'h100, 32'h0);

    // R4 reserved bits dropped
    wr(12'h10C, 32'hFFFF_FFFF);
    rd_exp("R4 ctl3 fields", 12'h10C, 32'hFFFF_1FF9);
    wr(12'h10C, 32'h0);

    // R2 disabled: no counting
    wr(12'h100, 32'h0003_02F0);         // sel 2, mask 0003, level F
    pulse(2, 16'h0001, 5);
    rd_exp("R2 gated", 12'h080, 32'd0);

    // R5 counting with mask
    wr(12'h000, 32'h1);
    pulse(2, 16'h0001, 5);
    pulse(2, 16'h0020, 3);               // masked out
    pulse(3, 16'hFFFF, 2);               // other group
    rd_exp("R5 count", 12'h080, 32'd5);

    // R6 privilege filter
    wr(12'h100, 32'h0003_0220);          // level 2, kcnt 0
    priv = 4'd3;
    pulse(2, 16'h0002, 4);
    rd_exp("R6 blocked", 12'h080, 32'd5);
    wr(12'h100, 32'h0003_0228);          // kcnt 1
    kern = 1'b1;
    pulse(2, 16'h0002, 4);
    rd_exp("R6 kernel", 12'h080, 32'd9);
    kern = 1'b0; priv = 4'd1;
    pulse(2, 16'h0002, 2);
    rd_exp("R6 level", 12'h080, 32'd11);
    priv = 4'd0;

    // R7 overflow with interrupt
    wr(12'h100, 32'h0003_02F1);
    wr(12'h080, 32'hFFFF_FFFE);
    pulse(2, 16'h0001, 3);
    rd_exp("R7 wrapped", 12'h080, 32'd1);
    rd_exp("R7 status", 12'h180, 32'h11);
    chk("R9 irq high", {31'd0, irq}, 32'd1);

    // R8 write-one-to-clear
    wr(12'h180, 32'h1);
    rd_exp("R8 ovf cleared", 12'h180, 32'h10);
    wr(12'h180, 32'h0);
    rd_exp("R8 zero no effect", 12'h180, 32'h10);
    wr(12'h180, 32'h10);
    rd_exp("R8 ia cleared", 12'h180, 32'h0);
    chk("R9 irq low", {31'd0, irq}, 32'd0);

    // R10 chaining
    wr(12'h100, 32'h0003_02F0);          // no ien on counter 0
    wr(12'h104, 32'h0000_0101);          // sel 1, ien, level 0
    wr(12'h080, 32'hFFFF_FFFF);
    priv = 4'd5;                          // filter would block counter 1
    pulse(2, 16'h0001, 1);
    rd_exp("R10 chained", 12'h084, 32'd1);
    rd_exp("R10 st0", 12'h180, 32'h1);
    wr(12'h100, 32'h0000_0100);          // counter 0 chained: never steps
    pulse(2, 16'h0001, 3);
    rd_exp("R10 head", 12'h080, 32'd0);
    priv = 4'd0;

    // R11 write wins over step
    wr(12'h100, 32'h0003_02F0);
    @(negedge clk);
    evt[2*16 +: 16] = 16'h1;
    wr(12'h080, 32'hFFFF_FFFF);
    evt = '0;
    rd_exp("R11 loaded", 12'h080, 32'hFFFF_FFFF);
    rd_exp("R11 no wrap", 12'h184, 32'h0);

    // R12 zero control stops
    wr(12'h080, 32'd77);
    wr(12'h100, 32'h0);
    pulse(2, 16'hFFFF, 4);
    rd_exp("R12 held", 12'h080, 32'd77);
    rd_exp("R12 st held", 12'h180, 32'h1);

    // R3 unmapped offsets and low address bits
    rd_exp("R3 gap", 12'h004, 32'h0);
    rd_exp("R3 past bank", 12'(12'h080 + 4*NC), 32'h0);
    rd_exp("R3 high", 12'h200, 32'h0);
    rd_exp("R3 low bits", 12'h083, 32'd77);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'(12'h100 + 4*NC), 32'hFFFF_FFFF);
    wr(12'h280, 32'hFFFF_FFFF);
    rd_all("R3 after stray writes");

    // mixed random phase
    wr(12'h100, 32'hFFFF_00F1);
    wr(12'h080, 32'hFFFF_FF00);
    wr(12'h104, 32'h0000_01F1);
    wr(12'h084, 32'hFFFF_FFFE);
    wr(12'h108, 32'h0101_0319);
    wr(12'h10C, 32'h8000_0700);
    for (int c = 0; c < 1500; c++) begin
      @(negedge clk);
      for (int g = 0; g < NG; g++) evt[g*16 +: 16] = 16'($urandom);
      priv = 4'($urandom_range(0, 3));
      kern = 1'($urandom);
      if (c % 60 == 59) rd_all("R5 R7 R10 random");
      if (c % 400 == 399) begin
        for (int i = 0; i < NC; i++) wr(12'(12'h180 + 4*i), 32'h11);
      end
    end
    evt = '0;
    rd_all("R7 R8 final");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule